// File: doc/BRIEF.md
# Coin Credit Vending Controller

This block is a synchronous Moore state machine that keeps a running credit total as coins are inserted and releases one item when the total reaches the item price of 4 credits. Two coin values exist, worth 1 and 2 credits, and each has its own detector input. Each detector delivers a single-cycle pulse per coin. A coin that makes the total exactly 4 releases the item. A 2-credit coin inserted at 3 credits makes the total 5, so the block releases the item and also returns one credit of change.

The states are CREDIT0, CREDIT1, CREDIT2 and CREDIT3, which hold the accumulated credit, and VEND and VEND_CHANGE, which are the dispense states. The transitions are as follows:
- A 1-credit coin moves CREDITn to CREDITn+1. From CREDIT3 it moves to VEND.
- A 2-credit coin moves CREDITn to CREDITn+2. From CREDIT2 it moves to VEND, and from CREDIT3 it moves to VEND_CHANGE.
- With no coin, or with both detectors pulsing in the same cycle, a credit state holds.
- VEND and VEND_CHANGE always return to CREDIT0 on the next clock, whatever the coin inputs are.

The outputs are decoded from the state alone.

Top module: `vend_fsm`

## Requirements
- R1: While `rst` is high at a rising clock edge, the machine goes to CREDIT0, and `dispense` and `change` are both low after that edge.
- R2: A pulse on `coin_one` alone adds 1 credit to the total held in a credit state.
- R3: A pulse on `coin_two` alone adds 2 credits to the total held in a credit state.
- R4: A coin that brings the total to exactly 4 credits enters VEND. After that edge `dispense` is 1 and `change` is 0. This covers the sequences 1+1+1+1, 1+1+2, 1+2+1, 2+1+1 and 2+2.
- R5: A 2-credit coin inserted at 3 credits enters VEND_CHANGE. After that edge `dispense` is 1 and `change` is 1. This covers the sequences 1+1+1+2, 1+2+2 and 2+1+2.
- R6: `dispense` and `change` stay high for exactly one clock cycle. The machine then returns to CREDIT0.
- R7: If `coin_one` and `coin_two` are both high in the same cycle, the event is ignored and the credit total does not change.
- R8: Coin pulses that arrive while the machine is in VEND or VEND_CHANGE are ignored. The next item still needs a full 4 credits.
- R9: With neither coin input high, a credit state holds its total.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| coin_one | input | 1 | Single-cycle pulse for a 1-credit coin |
| coin_two | input | 1 | Single-cycle pulse for a 2-credit coin |
| dispense | output | 1 | High for one cycle when the item is released |
| change | output | 1 | High for one cycle when one credit is returned |

## Verification
The block has no parameters, so the bench builds it as it stands with its fixed 4-credit price. This lets every coin order that reaches or passes 4 credits be driven directly. Those orders include 2+2, which must release the item only, and 1+1+1+2, which must release the item and return change. Further cases probe the credit total through the outputs: a simultaneous pulse on both detectors, and coins inserted during a dispense cycle. In each case a known number of extra credits is then added, and the bench checks whether the item is released too early or on time.

// File: rtl/vend_pkg.sv
package vend_pkg;

    typedef enum logic [2:0] {
        S_CREDIT0     = 3'd0,
        S_CREDIT1     = 3'd1,
        S_CREDIT2     = 3'd2,
        S_CREDIT3     = 3'd3,
        S_VEND        = 3'd4,
        S_VEND_CHANGE = 3'd5
    } vend_state_e;

    typedef enum logic [1:0] {
        COIN_NONE = 2'd0,
        COIN_ONE  = 2'd1,
        COIN_TWO  = 2'd2
    } coin_evt_e;

endpackage

// File: rtl/vend_coin_decode.sv
module vend_coin_decode
    import vend_pkg::*;
(
    input  logic      coin_one,
    input  logic      coin_two,
    output coin_evt_e evt
);

    // Both detectors firing together is treated as no coin (R7).
    always_comb begin
        unique case ({coin_two, coin_one})
            2'b01:   evt = COIN_ONE;
            2'b10:   evt = COIN_TWO;
            default: evt = COIN_NONE;
        endcase
    end

endmodule

// File: rtl/vend_fsm.sv
module vend_fsm
    import vend_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic coin_one,
    input  logic coin_two,
    output logic dispense,
    output logic change
);

    vend_state_e state_q;
    vend_state_e state_d;
    coin_evt_e   evt;

    vend_coin_decode u_decode (
        .coin_one (coin_one),
        .coin_two (coin_two),
        .evt      (evt)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_CREDIT0: begin
                if (evt == COIN_ONE)      state_d = S_CREDIT1;
                else if (evt == COIN_TWO) state_d = S_CREDIT2;
            end
            S_CREDIT1: begin
                if (evt == COIN_ONE)      state_d = S_CREDIT2;
                else if (evt == COIN_TWO) state_d = S_CREDIT3;
            end
            S_CREDIT2: begin
                if (evt == COIN_ONE)      state_d = S_CREDIT3;
                else if (evt == COIN_TWO) state_d = S_VEND;
            end
            S_CREDIT3: begin
                if (evt == COIN_ONE)      state_d = S_VEND;
                else if (evt == COIN_TWO) state_d = S_VEND_CHANGE;
            end
            S_VEND, S_VEND_CHANGE: state_d = S_CREDIT0;
            default:               state_d = S_CREDIT0;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) state_q <= S_CREDIT0;
        else     state_q <= state_d;
    end

    // Moore output decode.
    always_comb begin
        dispense = 1'b0;
        change   = 1'b0;
        unique case (state_q)
            S_VEND:        dispense = 1'b1;
            S_VEND_CHANGE: begin
                dispense = 1'b1;
                change   = 1'b1;
            end
            default: ;
        endcase
    end

    // Assertions
    p_change_needs_dispense_r5: assert property (@(posedge clk) disable iff (rst)
        change |-> dispense);

    p_two_at_three_gives_change_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_CREDIT3 && coin_two && !coin_one) |=> (dispense && change));

    p_dispense_single_cycle_r6: assert property (@(posedge clk) disable iff (rst)
        dispense |=> (!dispense && state_q == S_CREDIT0));

    p_both_coins_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (coin_one && coin_two && !dispense) |=> (state_q == $past(state_q)));

    p_idle_holds_r9: assert property (@(posedge clk) disable iff (rst)
        (!coin_one && !coin_two && !dispense) |=> (state_q == $past(state_q)));

    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (!dispense && !change));

endmodule

// File: tb/vend_fsm_test.sv
module vend_fsm_test;

    logic clk = 1'b0;
    logic rst;
    logic coin_one;
    logic coin_two;
    logic dispense;
    logic change;

    int vectors = 0;
    int errors  = 0;

    always #10 clk = ~clk;

    vend_fsm uut (
        .clk      (clk),
        .rst      (rst),
        .coin_one (coin_one),
        .coin_two (coin_two),
        .dispense (dispense),
        .change   (change)
    );

    task automatic check(input logic exp_d, input logic exp_c, input string req);
        vectors++;
        if (dispense !== exp_d || change !== exp_c) begin
            errors++;
            $display("FAIL %s: dispense/change=%b%b expected %b%b", req, dispense, change, exp_d, exp_c);
        end
    endtask

    // Drives one pulse from a falling edge to the next; the outputs then show the new state.
    task automatic pulse(input logic one, input logic two);
        coin_one = one;
        coin_two = two;
        @(negedge clk);
        coin_one = 1'b0;
        coin_two = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        coin_one = 1'b0;
        coin_two = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(1'b0, 1'b0, "R1");
    endtask

    // Insert a coin sequence (1 or 2 per element). Every coin before the last must leave the outputs low.
    task automatic run_seq(input int c0, input int c1, input int c2, input int c3,
                           input int n, input logic exp_chg, input string req);
        int coins[4];
        coins = '{c0, c1, c2, c3};
        for (int i = 0; i < n; i++) begin
            pulse(coins[i] == 1, coins[i] == 2);
            if (i < n - 1) check(1'b0, 1'b0, coins[i] == 1 ? "R2" : "R3");
            else           check(1'b1, exp_chg, req);
        end
        @(negedge clk);
        check(1'b0, 1'b0, "R6");
    endtask

    task automatic test_exact_four();
        run_seq(2, 2, 0, 0, 2, 1'b0, "R4");
        run_seq(1, 1, 1, 1, 4, 1'b0, "R4");
        run_seq(1, 1, 2, 0, 3, 1'b0, "R4");
        run_seq(1, 2, 1, 0, 3, 1'b0, "R4");
        run_seq(2, 1, 1, 0, 3, 1'b0, "R4");
    endtask

    task automatic test_with_change();
        run_seq(1, 1, 1, 2, 4, 1'b1, "R5");
        run_seq(1, 2, 2, 0, 3, 1'b1, "R5");
        run_seq(2, 1, 2, 0, 3, 1'b1, "R5");
    endtask

    // R7: both pulses at 1 credit; then 1+2 must reach exactly 4 and no more.
    task automatic test_both_ignored();
        pulse(1'b1, 1'b0);
        pulse(1'b1, 1'b1);
        check(1'b0, 1'b0, "R7");
        pulse(1'b1, 1'b0);
        check(1'b0, 1'b0, "R7");
        pulse(1'b0, 1'b1);
        check(1'b1, 1'b0, "R7");
        @(negedge clk);
        check(1'b0, 1'b0, "R6");
    endtask

    // R8: a 2-credit coin during the VEND cycle must not count.
    task automatic test_ignore_in_vend();
        pulse(1'b0, 1'b1);
        pulse(1'b0, 1'b1);
        check(1'b1, 1'b0, "R4");
        pulse(1'b0, 1'b1);
        check(1'b0, 1'b0, "R8");
        pulse(1'b1, 1'b0);
        pulse(1'b1, 1'b0);
        pulse(1'b1, 1'b0);
        check(1'b0, 1'b0, "R8");
        pulse(1'b1, 1'b0);
        check(1'b1, 1'b0, "R8");
        @(negedge clk);
    endtask

    // R9: idle gaps keep the credit.
    task automatic test_idle_hold();
        pulse(1'b1, 1'b0);
        repeat (5) @(negedge clk);
        check(1'b0, 1'b0, "R9");
        pulse(1'b0, 1'b1);
        repeat (3) @(negedge clk);
        check(1'b0, 1'b0, "R9");
        pulse(1'b0, 1'b1);
        check(1'b1, 1'b1, "R9");
        @(negedge clk);
        check(1'b0, 1'b0, "R6");
    endtask

    // R1: reset in mid-credit discards the credit.
    task automatic test_reset_mid();
        pulse(1'b1, 1'b0);
        pulse(1'b1, 1'b0);
        do_reset();
        pulse(1'b0, 1'b1);
        check(1'b0, 1'b0, "R1");
        pulse(1'b0, 1'b1);
        check(1'b1, 1'b0, "R1");
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        test_exact_four();
        test_with_change();
        test_both_ignored();
        test_ignore_in_vend();
        test_idle_hold();
        test_reset_mid();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule